// File: doc/BRIEF.md
# SDRAM Per-Bank Command Legality Monitor

This block watches the command bus of a four-bank synchronous DRAM and never drives it. Each clock it decodes the strobes, the bank select and the address. It keeps a model of what every bank is doing and judges each command against the state of the bank it targets. Commands that act on all banks are judged against all four states. A rule violation produces a one-cycle flag and a code that names the rule.

Each bank's model counts out its own recovery windows, using clock-cycle parameters:

- the delay from write to precharge,
- the precharge time,
- the refresh cycle time,
- the mode-register access time.

The model also tracks the delay from activate to column command, and the spacing between activates. Illegal commands are reported and then discarded: they never change the model. The monitor is meant for simulation benches and for on-chip debug next to a memory controller.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: After reset every bank reads idle (state code 0), and `illegal_o` is low with code 0.
- R2: Command decoding and state encoding:
  - Commands are decoded active-low. `cs_n_i` high is deselect. With `cs_n_i` low, `{ras_n_i,cas_n_i,we_n_i}` decodes as: 000 mode set, 001 refresh, 010 precharge, 011 activate, 100 write, 101 read, 110 burst stop, 111 NOP.
  - Bank b's state is `bank_state_o[3b+2:3b]`: 0 idle, 1 row open, 2 write recovery, 3 write recovery then auto-close, 4 closing, 5 refreshing, 6 mode access, 7 self refresh.
  - The verdict on a command sampled at clock edge k is visible after edge k, with `illegal_o` high exactly when the code is non-zero.
  - A timed state entered at edge k for N cycles is left so that a command at edge k+N is judged by the exit state.
- R3: Mode set or refresh while any bank is not idle is flagged with code 1.
- R4: Activate checks:
  - An activate to a bank that is not idle is flagged with code 2.
  - An activate to an idle bank fewer than TRRD cycles after the last accepted activate is flagged with code 5.
- R5: Read and write checks:
  - A read or write to a bank in state 0, 4, 5, 6 or 7 is flagged with code 3.
  - A read or write to a bank in state 1 or 2 fewer than TRCD cycles after its activate is flagged with code 4.
- R6: Write without auto-close (`addr_i[10]`=0):
  - The write moves the bank to state 2. The bank returns to state 1 after TDPL cycles.
  - During state 2, a precharge to that bank is flagged with code 6 and an activate to it with code 2.
  - During state 2, a read is accepted and returns the bank to state 1.
- R7: Auto-close (`addr_i[10]`=1):
  - A write moves the bank to state 3. During state 3, a read, write or precharge to that bank is flagged with code 6.
  - After TDPL cycles the bank enters state 4, and it is idle TRP cycles later.
  - A read with auto-close moves the bank to state 4, and it is idle after TRP cycles.
- R8: Refresh with `cke_i` high:
  - All banks enter state 5 for TRC cycles, then return to idle.
  - Meanwhile an activate or precharge is flagged with code 2, and a read or write with code 3.
  - Burst stop stays legal.
- R9: Mode set puts all banks in state 6 for TMRD cycles. Burst stop is flagged with code 7 while any bank is in state 6.
- R10: Refresh with `cke_i` low puts all banks in state 7:
  - While any bank is in state 7, no command is checked or acted on.
  - The first cycle with `cke_i` high moves all banks to state 5, and they become idle TRC cycles later.
- R11: A command that is illegal only because of one bank's state is flagged only when the bank select points at that bank. A command to another bank is judged by that bank's own state.
- R12: A flagged command changes no bank state and restarts no timer. Burst stop, NOP and deselect change no bank state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of the memory command bus |
| rst_n | input | 1 | Active-low synchronous reset |
| cke_i | input | 1 | Clock enable seen by the memory |
| cs_n_i | input | 1 | Chip select, active low |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write enable, active low |
| bs_i | input | 2 | Bank select |
| addr_i | input | ADDR_W (12) | Row/column address; bit AP_BIT (10) selects auto-close |
| illegal_o | output | 1 | One-cycle pulse for an illegal command |
| viol_code_o | output | 3 | Rule code of the flagged command, 0 otherwise |
| bank_state_o | output | 12 | Packed 3-bit state per bank |

## Verification
The assertions rely on the bus being driven with known values every cycle. They also rely on every interval parameter being at least two cycles. The state-exit properties further assume that `cke_i` only falls together with a refresh command, so that self refresh is only entered through the monitored path. The bench drives the strobes as whole command patterns on the falling edge and keeps `cke_i` high except around self-refresh entry. It uses a small timing configuration, and the interval sweeps step the command distance across each limit from one cycle below to one above.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;

    localparam int BS_W = 2;
    localparam int NB   = 1 << BS_W;

    typedef enum logic [3:0] {
        CMD_MRS, CMD_REF, CMD_PRE, CMD_ACT,
        CMD_WR,  CMD_RD,  CMD_BST, CMD_NOP, CMD_DESEL
    } cmd_e;

    typedef enum logic [2:0] {
        BK_IDLE    = 3'd0,
        BK_ACTIVE  = 3'd1,
        BK_WREC    = 3'd2,
        BK_WREC_AP = 3'd3,
        BK_PRECH   = 3'd4,
        BK_REFR    = 3'd5,
        BK_MODE    = 3'd6,
        BK_SELF    = 3'd7
    } bank_st_e;

    typedef enum logic [2:0] {
        V_NONE         = 3'd0,
        V_NOT_ALL_IDLE = 3'd1,
        V_BANK_BUSY    = 3'd2,
        V_NO_ROW       = 3'd3,
        V_RCD          = 3'd4,
        V_RRD          = 3'd5,
        V_RECOVERY     = 3'd6,
        V_MODE_BUSY    = 3'd7
    } viol_e;

    typedef struct packed {
        cmd_e            op;
        logic [BS_W-1:0] bank;
        logic            auto_pre;
        logic            cke;
    } cmd_t;

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
    import sdram_mon_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int AP_BIT = 10
) (
    input  logic              cke,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [BS_W-1:0]   bs,
    input  logic [ADDR_W-1:0] addr,
    output cmd_t              cmd
);

    // only the auto-close bit matters to the bank model
    logic unused_addr_bits;
    assign unused_addr_bits = ^{addr[ADDR_W-1:AP_BIT+1], addr[AP_BIT-1:0]};

    always_comb begin
        cmd.bank     = bs;
        cmd.auto_pre = addr[AP_BIT];
        cmd.cke      = cke;
        if (cs_n) begin
            cmd.op = CMD_DESEL;
        end else begin
            unique case ({ras_n, cas_n, we_n})
                3'b000:  cmd.op = CMD_MRS;
                3'b001:  cmd.op = CMD_REF;
                3'b010:  cmd.op = CMD_PRE;
                3'b011:  cmd.op = CMD_ACT;
                3'b100:  cmd.op = CMD_WR;
                3'b101:  cmd.op = CMD_RD;
                3'b110:  cmd.op = CMD_BST;
                default: cmd.op = CMD_NOP;
            endcase
        end
    end

endmodule

// File: rtl/sdram_rule_check.sv
module sdram_rule_check
    import sdram_mon_pkg::*;
(
    input  cmd_e                 op,
    input  logic [BS_W-1:0]      bank,
    input  logic [NB-1:0][2:0]   bank_st,
    input  logic [NB-1:0]        rcd_busy,
    input  logic                 rrd_busy,
    output logic                 all_idle_o,
    output viol_e                code_o
);

    bank_st_e tgt;
    logic     any_mode;

    always_comb begin
        all_idle_o = 1'b1;
        any_mode   = 1'b0;
        for (int b = 0; b < NB; b++) begin
            if (bank_st[b] != BK_IDLE) all_idle_o = 1'b0;
            if (bank_st[b] == BK_MODE) any_mode   = 1'b1;
        end
        tgt = bank_st_e'(bank_st[bank]);
    end

    always_comb begin
        code_o = V_NONE;
        unique case (op)
            CMD_MRS, CMD_REF: begin
                if (!all_idle_o) code_o = V_NOT_ALL_IDLE;
            end
            CMD_ACT: begin
                if (tgt != BK_IDLE)  code_o = V_BANK_BUSY;
                else if (rrd_busy)   code_o = V_RRD;
            end
            CMD_RD, CMD_WR: begin
                unique case (tgt)
                    BK_ACTIVE, BK_WREC: if (rcd_busy[bank]) code_o = V_RCD;
                    BK_WREC_AP:         code_o = V_RECOVERY;
                    default:            code_o = V_NO_ROW;
                endcase
            end
            CMD_PRE: begin
                unique case (tgt)
                    BK_WREC, BK_WREC_AP: code_o = V_RECOVERY;
                    BK_REFR, BK_MODE:    code_o = V_BANK_BUSY;
                    default:             code_o = V_NONE;
                endcase
            end
            CMD_BST: begin
                if (any_mode) code_o = V_MODE_BUSY;
            end
            default: code_o = V_NONE;
        endcase
    end

endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
    import sdram_mon_pkg::*;
#(
    parameter int TRCD  = 3,
    parameter int TDPL  = 2,
    parameter int TRP   = 3,
    parameter int TRC   = 7,
    parameter int TMRD  = 2,
    parameter int CNT_W = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  cmd_e     op,
    input  logic     auto_pre,
    input  logic     cke,
    input  logic     hit,
    input  logic     accept,
    output bank_st_e state_o,
    output logic     rcd_busy_o
);

    localparam logic [CNT_W-1:0] LD_TRCD  = CNT_W'(TRCD - 1);
    localparam logic [CNT_W-1:0] LD_TDPL  = CNT_W'(TDPL - 1);
    localparam logic [CNT_W-1:0] LD_TRP   = CNT_W'(TRP - 1);
    localparam logic [CNT_W-1:0] LD_TRP_C = CNT_W'(TRP);
    localparam logic [CNT_W-1:0] LD_TRC   = CNT_W'(TRC - 1);
    localparam logic [CNT_W-1:0] LD_TMRD  = CNT_W'(TMRD - 1);
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

    typedef struct packed {
        bank_st_e         st;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] rcd;
    } trk_t;

    trk_t trk_d, trk_q;
    logic last_tick;

    assign last_tick = (trk_q.cnt <= ONE);

    always_comb begin
        trk_d = trk_q;
        if (trk_q.rcd != '0) trk_d.rcd = trk_q.rcd - 1'b1;

        // interval countdown of the timed states
        unique case (trk_q.st)
            BK_WREC: begin
                if (last_tick) begin
                    trk_d.st  = BK_ACTIVE;
                    trk_d.cnt = '0;
                end else trk_d.cnt = trk_q.cnt - 1'b1;
            end
            BK_WREC_AP: begin
                if (last_tick) begin
                    trk_d.st  = BK_PRECH;
                    trk_d.cnt = LD_TRP_C;
                end else trk_d.cnt = trk_q.cnt - 1'b1;
            end
            BK_PRECH, BK_REFR, BK_MODE: begin
                if (last_tick) begin
                    trk_d.st  = BK_IDLE;
                    trk_d.cnt = '0;
                end else trk_d.cnt = trk_q.cnt - 1'b1;
            end
            BK_SELF: begin
                if (cke) begin
                    trk_d.st  = BK_REFR;
                    trk_d.cnt = LD_TRC;
                end
            end
            default: ;
        endcase

        // accepted commands override the countdown
        if (accept) begin
            unique case (op)
                CMD_MRS: begin
                    trk_d.st  = BK_MODE;
                    trk_d.cnt = LD_TMRD;
                end
                CMD_REF: begin
                    trk_d.st  = cke ? BK_REFR : BK_SELF;
                    trk_d.cnt = cke ? LD_TRC : '0;
                end
                CMD_ACT: if (hit) begin
                    trk_d.st  = BK_ACTIVE;
                    trk_d.cnt = '0;
                    trk_d.rcd = LD_TRCD;
                end
                CMD_WR: if (hit) begin
                    trk_d.st  = auto_pre ? BK_WREC_AP : BK_WREC;
                    trk_d.cnt = LD_TDPL;
                end
                CMD_RD: if (hit) begin
                    trk_d.st  = auto_pre ? BK_PRECH : BK_ACTIVE;
                    trk_d.cnt = auto_pre ? LD_TRP : '0;
                end
                CMD_PRE: if (hit && trk_q.st == BK_ACTIVE) begin
                    trk_d.st  = BK_PRECH;
                    trk_d.cnt = LD_TRP;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trk_q.st  <= BK_IDLE;
            trk_q.cnt <= '0;
            trk_q.rcd <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign state_o    = trk_q.st;
    assign rcd_busy_o = (trk_q.rcd != '0);

    AST_MODE_EXIT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        trk_q.st == BK_MODE |=> (trk_q.st == BK_MODE || trk_q.st == BK_IDLE)); // R9
    AST_REFR_EXIT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        trk_q.st == BK_REFR |=> (trk_q.st == BK_REFR || trk_q.st == BK_IDLE)); // R8
    AST_SELF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (trk_q.st == BK_SELF && !cke) |=> trk_q.st == BK_SELF); // R10
    AST_WREC_PRE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (trk_q.st == BK_WREC && hit && op == CMD_PRE)
        |=> (trk_q.st == BK_WREC || trk_q.st == BK_ACTIVE)); // R6
    AST_AP_NO_REOPEN: assert property (@(posedge clk) disable iff (!rst_n)
        trk_q.st == BK_WREC_AP |=> (trk_q.st == BK_WREC_AP || trk_q.st == BK_PRECH)); // R7

endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
    import sdram_mon_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int AP_BIT = 10,
    parameter int TRCD   = 3,
    parameter int TRRD   = 2,
    parameter int TDPL   = 2,
    parameter int TRP    = 3,
    parameter int TRC    = 7,
    parameter int TMRD   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke_i,
    input  logic              cs_n_i,
    input  logic              ras_n_i,
    input  logic              cas_n_i,
    input  logic              we_n_i,
    input  logic [BS_W-1:0]   bs_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              illegal_o,
    output logic [2:0]        viol_code_o,
    output logic [3*NB-1:0]   bank_state_o
);

    localparam int MAX_A = (TRCD > TDPL) ? TRCD : TDPL;
    localparam int MAX_B = (TRP  > TRC ) ? TRP  : TRC;
    localparam int MAX_C = (TMRD > TRRD) ? TMRD : TRRD;
    localparam int MAX_AB = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAXT  = (MAX_AB > MAX_C) ? MAX_AB : MAX_C;
    localparam int CNT_W = $clog2(MAXT + 1);
    localparam logic [CNT_W-1:0] LD_TRRD = CNT_W'(TRRD - 1);

    typedef struct packed {
        logic             illegal;
        viol_e            code;
        logic [CNT_W-1:0] rrd;
    } top_t;

    cmd_t               cmd;
    bank_st_e           st_arr [NB];
    logic [NB-1:0][2:0] st_vec;
    logic [NB-1:0]      rcd_busy;
    logic               all_idle;
    logic               any_self;
    logic               accept;
    viol_e              code;
    top_t               top_d, top_q;

    sdram_cmd_decode #(
        .ADDR_W (ADDR_W),
        .AP_BIT (AP_BIT)
    ) u_decode (
        .cke   (cke_i),
        .cs_n  (cs_n_i),
        .ras_n (ras_n_i),
        .cas_n (cas_n_i),
        .we_n  (we_n_i),
        .bs    (bs_i),
        .addr  (addr_i),
        .cmd   (cmd)
    );

    for (genvar b = 0; b < NB; b++) begin : g_bank
        sdram_bank_tracker #(
            .TRCD  (TRCD),
            .TDPL  (TDPL),
            .TRP   (TRP),
            .TRC   (TRC),
            .TMRD  (TMRD),
            .CNT_W (CNT_W)
        ) u_trk (
            .clk        (clk),
            .rst_n      (rst_n),
            .op         (cmd.op),
            .auto_pre   (cmd.auto_pre),
            .cke        (cmd.cke),
            .hit        (cmd.bank == BS_W'(b)),
            .accept     (accept),
            .state_o    (st_arr[b]),
            .rcd_busy_o (rcd_busy[b])
        );
        assign st_vec[b]            = st_arr[b];
        assign bank_state_o[3*b +: 3] = st_arr[b];
    end

    sdram_rule_check u_rules (
        .op         (cmd.op),
        .bank       (cmd.bank),
        .bank_st    (st_vec),
        .rcd_busy   (rcd_busy),
        .rrd_busy   (top_q.rrd != '0),
        .all_idle_o (all_idle),
        .code_o     (code)
    );

    always_comb begin
        any_self = 1'b0;
        for (int b = 0; b < NB; b++) begin
            if (st_vec[b] == BK_SELF) any_self = 1'b1;
        end
    end

    assign accept = !any_self && (code == V_NONE);

    always_comb begin
        top_d = top_q;
        if (top_q.rrd != '0) top_d.rrd = top_q.rrd - 1'b1;
        if (accept && cmd.op == CMD_ACT) top_d.rrd = LD_TRRD;
        top_d.code    = any_self ? V_NONE : code;
        top_d.illegal = !any_self && (code != V_NONE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_q.illegal <= 1'b0;
            top_q.code    <= V_NONE;
            top_q.rrd     <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    assign illegal_o   = top_q.illegal;
    assign viol_code_o = top_q.code;

    AST_FLAG_HAS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> viol_code_o != 3'd0); // R2
    AST_GLOBAL_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd.op == CMD_MRS || cmd.op == CMD_REF) && !any_self && !all_idle)
        |=> (illegal_o && viol_code_o == 3'd1)); // R3
    AST_SELF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        any_self |=> !illegal_o); // R10
    AST_NOP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.op == CMD_NOP || cmd.op == CMD_DESEL) |=> !illegal_o); // R12

endmodule

// File: tb/sdram_cmd_monitor_bench.sv
`timescale 1ns/1ps
module sdram_cmd_monitor_bench;

    localparam int TRCD = 3;
    localparam int TRRD = 2;
    localparam int TDPL = 2;
    localparam int TRP  = 3;
    localparam int TRC  = 6;
    localparam int TMRD = 2;

    localparam logic [3:0] P_MRS = 4'b0000;
    localparam logic [3:0] P_REF = 4'b0001;
    localparam logic [3:0] P_PRE = 4'b0010;
    localparam logic [3:0] P_ACT = 4'b0011;
    localparam logic [3:0] P_WR  = 4'b0100;
    localparam logic [3:0] P_RD  = 4'b0101;
    localparam logic [3:0] P_BST = 4'b0110;
    localparam logic [3:0] P_NOP = 4'b0111;
    localparam logic [3:0] P_DES = 4'b1111;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cke = 1'b1;
    logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0]  bs = '0;
    logic [11:0] addr = '0;
    logic        illegal_o;
    logic [2:0]  viol_code_o;
    logic [11:0] bank_state_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    sdram_cmd_monitor #(
        .TRCD (TRCD), .TRRD (TRRD), .TDPL (TDPL),
        .TRP  (TRP),  .TRC  (TRC),  .TMRD (TMRD)
    ) u_sdram_cmd_monitor (
        .clk          (clk),
        .rst_n        (rst_n),
        .cke_i        (cke),
        .cs_n_i       (cs_n),
        .ras_n_i      (ras_n),
        .cas_n_i      (cas_n),
        .we_n_i       (we_n),
        .bs_i         (bs),
        .addr_i       (addr),
        .illegal_o    (illegal_o),
        .viol_code_o  (viol_code_o),
        .bank_state_o (bank_state_o)
    );

    task automatic drive(input logic [3:0] p, input int b, input logic ap, input logic ck);
        {cs_n, ras_n, cas_n, we_n} = p;
        bs   = 2'(b);
        addr = {1'b1, ap, 10'h2a5};
        cke  = ck;
        @(negedge clk);
    endtask

    task automatic issue(input logic [3:0] p, input int b, input logic ap);
        drive(p, b, ap, 1'b1);
    endtask

    task automatic nops(input int n);
        for (int i = 0; i < n; i++) issue(P_NOP, 0, 1'b0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        {cs_n, ras_n, cas_n, we_n} = P_DES;
        cke = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic chk_flag(input string req, input logic ill, input logic [2:0] c);
        n_vec++;
        if (illegal_o !== ill || viol_code_o !== c) begin
            n_bad++;
            $display("FAIL %s: flag=%0b code=%0d expected flag=%0b code=%0d",
                     req, illegal_o, viol_code_o, ill, c);
        end
    endtask

    task automatic chk_st(input string req, input int b, input logic [2:0] e);
        n_vec++;
        if (bank_state_o[3*b +: 3] !== e) begin
            n_bad++;
            $display("FAIL %s: bank %0d state=%0d expected %0d",
                     req, b, bank_state_o[3*b +: 3], e);
        end
    endtask

    task automatic chk_all(input string req, input logic [2:0] e);
        for (int b = 0; b < 4; b++) chk_st(req, b, e);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(4 * 100000);
        n_bad++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        // R1: reset state
        do_reset();
        chk_flag("R1", 1'b0, 3'd0);
        chk_all("R1", 3'd0);
        issue(P_ACT, 1, 1'b0);
        do_reset();
        chk_all("R1 reset mid-run", 3'd0);

        // R2: decode and state encoding
        issue(P_ACT, 2, 1'b0);
        chk_flag("R2 activate", 1'b0, 3'd0);
        chk_st("R2 activate", 2, 3'd1);
        chk_st("R2 other bank", 0, 3'd0);

        // R5: TRCD sweep and read to a closed bank
        for (int d = 1; d <= TRCD + 1; d++) begin
            do_reset();
            issue(P_ACT, 0, 1'b0);
            nops(d - 1);
            issue(P_RD, 0, 1'b0);
            chk_flag("R5 tRCD", d < TRCD, (d < TRCD) ? 3'd4 : 3'd0);
        end
        do_reset();
        issue(P_WR, 3, 1'b0);
        chk_flag("R5 closed bank", 1'b1, 3'd3);

        // R4 and R12: TRRD sweep, a flagged activate opens nothing
        for (int d = 1; d <= TRRD + 1; d++) begin
            do_reset();
            issue(P_ACT, 0, 1'b0);
            nops(d - 1);
            issue(P_ACT, 1, 1'b0);
            chk_flag("R4 tRRD", d < TRRD, (d < TRRD) ? 3'd5 : 3'd0);
            chk_st("R12 flagged activate", 1, (d < TRRD) ? 3'd0 : 3'd1);
        end
        do_reset();
        issue(P_ACT, 3, 1'b0);
        nops(TRRD - 1);
        issue(P_ACT, 3, 1'b0);
        chk_flag("R4 busy bank", 1'b1, 3'd2);
        nops(TRCD - TRRD - 1);
        issue(P_RD, 3, 1'b0);
        chk_flag("R12 tRCD not restarted", 1'b0, 3'd0);

        // R3: global commands need all banks idle
        do_reset();
        issue(P_ACT, 0, 1'b0);
        issue(P_REF, 0, 1'b0);
        chk_flag("R3 refresh", 1'b1, 3'd1);
        issue(P_MRS, 2, 1'b0);
        chk_flag("R3 mode set", 1'b1, 3'd1);
        chk_st("R3 unchanged", 0, 3'd1);
        chk_st("R3 unchanged", 2, 3'd0);

        // R6: write recovery trace, precharge sweep, read and activate inside
        do_reset();
        issue(P_ACT, 2, 1'b0);
        nops(TRCD - 1);
        issue(P_WR, 2, 1'b0);
        for (int j = 0; j <= TDPL + 1; j++) begin
            if (j > 0) issue(P_NOP, 0, 1'b0);
            chk_st("R6 trace", 2, (j < TDPL - 1) ? 3'd2 : 3'd1);
        end
        for (int d = 1; d <= TDPL + 1; d++) begin
            do_reset();
            issue(P_ACT, 2, 1'b0);
            nops(TRCD - 1);
            issue(P_WR, 2, 1'b0);
            nops(d - 1);
            issue(P_PRE, 2, 1'b0);
            chk_flag("R6 precharge", d < TDPL, (d < TDPL) ? 3'd6 : 3'd0);
            chk_st("R6 precharge", 2, (d < TDPL) ? 3'd1 : 3'd4);
        end
        do_reset();
        issue(P_ACT, 2, 1'b0);
        nops(TRCD - 1);
        issue(P_WR, 2, 1'b0);
        issue(P_ACT, 2, 1'b0);
        chk_flag("R6 activate", 1'b1, 3'd2);
        do_reset();
        issue(P_ACT, 2, 1'b0);
        nops(TRCD - 1);
        issue(P_WR, 2, 1'b0);
        issue(P_RD, 2, 1'b0);
        chk_flag("R6 read", 1'b0, 3'd0);
        chk_st("R6 read", 2, 3'd1);

        // R7: auto-close write, blocked commands, chained trace, auto-close read
        for (int k = 0; k < 3; k++) begin
            do_reset();
            issue(P_ACT, 1, 1'b0);
            nops(TRCD - 1);
            issue(P_WR, 1, 1'b1);
            issue((k == 0) ? P_RD : (k == 1) ? P_WR : P_PRE, 1, 1'b0);
            chk_flag("R7 blocked", 1'b1, 3'd6);
        end
        do_reset();
        issue(P_ACT, 1, 1'b0);
        nops(TRCD - 1);
        issue(P_WR, 1, 1'b1);
        for (int j = 0; j <= TDPL + TRP + 1; j++) begin
            if (j > 0) issue(P_NOP, 0, 1'b0);
            chk_st("R7 write trace", 1,
                   (j < TDPL - 1) ? 3'd3 : (j < TDPL - 1 + TRP) ? 3'd4 : 3'd0);
        end
        do_reset();
        issue(P_ACT, 0, 1'b0);
        nops(TRCD - 1);
        issue(P_RD, 0, 1'b1);
        for (int j = 0; j <= TRP; j++) begin
            if (j > 0) issue(P_NOP, 0, 1'b0);
            chk_st("R7 read trace", 0, (j < TRP - 1) ? 3'd4 : 3'd0);
        end

        // R8: refresh, commands inside, exact exit
        for (int k = 0; k < 5; k++) begin
            do_reset();
            issue(P_REF, 0, 1'b0);
            issue((k == 0) ? P_ACT : (k == 1) ? P_RD : (k == 2) ? P_WR :
                  (k == 3) ? P_PRE : P_BST, 1, 1'b0);
            chk_flag("R8 inside refresh", k != 4,
                     (k == 0 || k == 3) ? 3'd2 : (k == 4) ? 3'd0 : 3'd3);
        end
        do_reset();
        issue(P_REF, 0, 1'b0);
        for (int j = 0; j <= TRC; j++) begin
            if (j > 0) issue(P_NOP, 0, 1'b0);
            chk_all("R8 trace", (j < TRC - 1) ? 3'd5 : 3'd0);
        end
        for (int d = TRC - 1; d <= TRC; d++) begin
            do_reset();
            issue(P_REF, 0, 1'b0);
            nops(d - 1);
            issue(P_ACT, 0, 1'b0);
            chk_flag("R8 tRC edge", d < TRC, (d < TRC) ? 3'd2 : 3'd0);
        end

        // R9: mode access
        do_reset();
        issue(P_MRS, 0, 1'b0);
        chk_all("R9 enter", 3'd6);
        issue(P_BST, 0, 1'b0);
        chk_flag("R9 burst stop", 1'b1, 3'd7);
        for (int d = TMRD - 1; d <= TMRD; d++) begin
            do_reset();
            issue(P_MRS, 0, 1'b0);
            nops(d - 1);
            issue(P_ACT, 3, 1'b0);
            chk_flag("R9 tMRD edge", d < TMRD, (d < TMRD) ? 3'd2 : 3'd0);
        end

        // R10: self refresh entry, silence, exit
        do_reset();
        drive(P_REF, 0, 1'b0, 1'b0);
        chk_flag("R10 entry", 1'b0, 3'd0);
        chk_all("R10 entry", 3'd7);
        drive(P_ACT, 0, 1'b0, 1'b0);
        chk_flag("R10 silent", 1'b0, 3'd0);
        drive(P_MRS, 0, 1'b0, 1'b0);
        chk_flag("R10 silent", 1'b0, 3'd0);
        chk_all("R10 held", 3'd7);
        issue(P_NOP, 0, 1'b0);
        chk_all("R10 exit", 3'd5);
        nops(TRC - 2);
        chk_all("R10 exit", 3'd5);
        issue(P_NOP, 0, 1'b0);
        chk_all("R10 idle", 3'd0);

        // R11: per-bank judgement
        do_reset();
        issue(P_ACT, 0, 1'b0);
        nops(TRRD - 1);
        issue(P_ACT, 1, 1'b0);
        nops(TRCD);
        issue(P_WR, 0, 1'b1);
        issue(P_RD, 1, 1'b0);
        chk_flag("R11 other bank", 1'b0, 3'd0);
        chk_st("R11 other bank", 1, 3'd1);
        chk_st("R11 own bank", 0, (TDPL - 1 > 1) ? 3'd3 : 3'd4);
        issue(P_PRE, 1, 1'b0);
        chk_flag("R11 other bank precharge", 1'b0, 3'd0);
        chk_st("R11 other bank precharge", 1, 3'd4);

        // R12: idle commands leave every bank alone
        do_reset();
        issue(P_ACT, 0, 1'b0);
        for (int k = 0; k < 3; k++) begin
            issue((k == 0) ? P_BST : (k == 1) ? P_NOP : P_DES, k, 1'b0);
            chk_flag("R12 idle command", 1'b0, 3'd0);
            chk_st("R12 idle command", 0, 3'd1);
            chk_st("R12 idle command", 1, 3'd0);
        end

        finish_run();
    end

endmodule